// File: doc/BRIEF.md
# Configuration Cycle Type Converter

This block sits where a bus-to-bus bridge looks at the address phase of a configuration transaction on its upstream bus. It works out how the bridge should handle that transaction. A Type 0 cycle that selects the bridge is claimed for the bridge's own registers. A Type 1 cycle that names the bridge's secondary bus is turned into a Type 0 cycle for the devices on that bus, with the device number remapped to a single IDSEL line. A Type 1 cycle that names a bus further down the hierarchy is passed on unchanged. A Type 1 write that uses the reserved all-ones device and function encoding on the secondary bus becomes a special cycle.

Each request is one address word plus a command code, presented together with a request strobe. The block returns a registered action code, the address word to drive on the downstream side, and a flag that limits converted accesses to one 32-bit data phase. The secondary and subordinate bus numbers come in as plain inputs. Bus signalling, data movement and retries belong to the surrounding logic.

Top module: `cfgconv_top`

## Requirements
- R1: While reset is asserted and after it is released, act_valid is 0, act_code is 0 (ignore), act_ad is 0 and act_single is 0 until the first request.
- R2: A request sampled with req_valid=1 at a clock edge produces its result at that same edge. act_valid is high for exactly one cycle. act_code, act_ad and act_single hold their values while req_valid is 0.
- R3: Config commands are read 4'hA and write 4'hB. With a config command and req_ad[1:0]=00, the action is claim (code 1) with act_ad equal to req_ad when own_idsel=1. When own_idsel=0, the action is ignore (code 0) with act_ad=0.
- R4: A config command with req_ad[1:0]=01 and bus field req_ad[23:16] equal to sec_bus, that is not a special cycle, gives convert (code 2). act_ad[1:0]=00, act_ad[10:2] equals req_ad[10:2], and act_ad[15:11]=0.
- R5: On convert, a device number d = req_ad[15:11] in the range 0..8 sets act_ad bit 16+d and no other bit of act_ad[31:16].
- R6: On convert, a device number above 8 leaves act_ad[31:16] all zero.
- R7: A config write with req_ad[1:0]=01, bus equal to sec_bus, device 31 and function req_ad[10:8]=7 gives special (code 4) with act_ad equal to req_ad. The same word on a config read gives convert.
- R8: A config command with req_ad[1:0]=01 and sec_bus < bus <= sub_bus gives pass (code 3) with act_ad equal to req_ad.
- R9: The action is ignore with act_ad=0 in three cases: a Type 1 word whose bus is below sec_bus or above sub_bus, any non-config command, and req_ad[1:0] of 10 or 11.
- R10: act_single is 1 exactly when the registered action is convert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Address phase present this cycle |
| req_cmd | input | 4 | Bus command code |
| req_ad | input | 32 | Address word of the configuration cycle |
| own_idsel | input | 1 | Bridge's own IDSEL during the address phase |
| sec_bus | input | 8 | Secondary bus number |
| sub_bus | input | 8 | Subordinate bus number |
| act_valid | output | 1 | One-cycle strobe: new action available |
| act_code | output | 3 | 0 ignore, 1 claim, 2 convert, 3 pass, 4 special |
| act_ad | output | 32 | Address word for the downstream side |
| act_single | output | 1 | Access limited to one data phase |

## Verification
Every result is due one clock edge after its request: the bench drives a request on a falling edge, lets one rising edge capture it, and compares all four outputs on the following falling edge. On the falling edge after that, it checks that the strobe has dropped. Hold behaviour is checked by presenting a different word with the strobe low and sampling one cycle later, when a wrongly enabled register would already have changed.

// File: rtl/cfgconv_pkg.sv
package cfgconv_pkg;
  typedef enum logic [2:0] {
    ACT_NONE    = 3'd0,
    ACT_CLAIM   = 3'd1,
    ACT_CONVERT = 3'd2,
    ACT_PASS    = 3'd3,
    ACT_SPECIAL = 3'd4
  } cfg_act_e;

  localparam logic [3:0] CMD_CFG_RD = 4'hA;
  localparam logic [3:0] CMD_CFG_WR = 4'hB;

  // field layout of a configuration address word
  localparam int TY_W     = 2;
  localparam int REG_LSB  = 2;
  localparam int FUNC_LSB = 8;
  localparam int FUNC_W   = 3;
  localparam int DEV_LSB  = 11;
  localparam int DEV_W    = 5;
  localparam int BUS_LSB  = 16;
  localparam int SEL_LSB  = 16;
endpackage

// File: rtl/cfg_idsel_gen.sv
module cfg_idsel_gen #(
  parameter int DEV_W     = 5,
  parameter int NUM_LINES = 9,
  parameter int OUT_W     = 16
) (
  input  logic [DEV_W-1:0] dev,
  output logic [OUT_W-1:0] lines
);
  localparam int USED = (NUM_LINES < OUT_W) ? NUM_LINES : OUT_W;

  for (genvar i = 0; i < OUT_W; i++) begin : g_line
    if (i < USED) begin : g_used
      assign lines[i] = (dev == DEV_W'(i));
    end else begin : g_unused
      assign lines[i] = 1'b0;
    end
  end

  // R5/R6: never more than one select line
  always_comb begin
    a_idsel_onehot_r5: assert ($onehot0(lines) || $isunknown(dev));
  end
endmodule

// File: rtl/cfg_field_decode.sv
module cfg_field_decode
  import cfgconv_pkg::*;
#(
  parameter int AW    = 32,
  parameter int BUS_W = 8
) (
  input  logic [3:0]       cmd,
  input  logic [AW-1:0]    ad,
  input  logic             own_sel,
  input  logic [BUS_W-1:0] sec,
  input  logic [BUS_W-1:0] sub,
  output cfg_act_e         act
);
  localparam logic [DEV_W-1:0]  DEV_ALL  = '1;
  localparam logic [FUNC_W-1:0] FUNC_ALL = '1;

  logic              is_cfg, is_wr;
  logic [TY_W-1:0]   ty;
  logic [BUS_W-1:0]  bus;
  logic [DEV_W-1:0]  dev;
  logic [FUNC_W-1:0] func;
  logic              spec_enc;

  assign is_cfg   = (cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR);
  assign is_wr    = (cmd == CMD_CFG_WR);
  assign ty       = ad[TY_W-1:0];
  assign bus      = ad[BUS_LSB +: BUS_W];
  assign dev      = ad[DEV_LSB +: DEV_W];
  assign func     = ad[FUNC_LSB +: FUNC_W];
  assign spec_enc = is_wr && (dev == DEV_ALL) && (func == FUNC_ALL);

  always_comb begin
    act = ACT_NONE;
    if (is_cfg) begin
      unique case (ty)
        2'b00: act = own_sel ? ACT_CLAIM : ACT_NONE;
        2'b01: begin
          if (bus == sec)
            act = spec_enc ? ACT_SPECIAL : ACT_CONVERT;
          else if ((bus > sec) && (bus <= sub))
            act = ACT_PASS;
          else
            act = ACT_NONE;
        end
        default: act = ACT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/cfgconv_top.sv
module cfgconv_top
  import cfgconv_pkg::*;
#(
  parameter int AW        = 32,
  parameter int BUS_W     = 8,
  parameter int NUM_IDSEL = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [3:0]       req_cmd,
  input  logic [AW-1:0]    req_ad,
  input  logic             own_idsel,
  input  logic [BUS_W-1:0] sec_bus,
  input  logic [BUS_W-1:0] sub_bus,
  output logic             act_valid,
  output logic [2:0]       act_code,
  output logic [AW-1:0]    act_ad,
  output logic             act_single
);
  localparam int SEL_W  = AW - SEL_LSB;
  localparam int KEEP_W = DEV_LSB - REG_LSB;

  cfg_act_e         act_d;
  logic [SEL_W-1:0] sel_lines;
  logic [AW-1:0]    ad_d;

  logic             valid_q;
  cfg_act_e         act_q;
  logic [AW-1:0]    ad_q;
  logic             single_q;

  cfg_field_decode #(.AW(AW), .BUS_W(BUS_W)) u_decode (
    .cmd     (req_cmd),
    .ad      (req_ad),
    .own_sel (own_idsel),
    .sec     (sec_bus),
    .sub     (sub_bus),
    .act     (act_d)
  );

  cfg_idsel_gen #(.DEV_W(DEV_W), .NUM_LINES(NUM_IDSEL), .OUT_W(SEL_W)) u_idsel (
    .dev   (req_ad[DEV_LSB +: DEV_W]),
    .lines (sel_lines)
  );

  // next-state word
  always_comb begin
    ad_d = '0;
    unique case (act_d)
      ACT_CLAIM, ACT_PASS, ACT_SPECIAL: ad_d = req_ad;
      ACT_CONVERT: ad_d = {sel_lines, {DEV_W{1'b0}},
                           req_ad[REG_LSB +: KEEP_W], {TY_W{1'b0}}};
      default: ad_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      act_q    <= ACT_NONE;
      ad_q     <= '0;
      single_q <= 1'b0;
    end else begin
      valid_q <= req_valid;
      if (req_valid) begin
        act_q    <= act_d;
        ad_q     <= ad_d;
        single_q <= (act_d == ACT_CONVERT);
      end
    end
  end

  assign act_valid  = valid_q;
  assign act_code   = act_q;
  assign act_ad     = ad_q;
  assign act_single = single_q;

  // R2: outputs hold without a request
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid) |-> ($stable(act_ad) && $stable(act_code)));
  // R4: converted word is Type 0
  p_type0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && act_code == ACT_CONVERT) |-> act_ad[1:0] == 2'b00);
  // R5: at most one IDSEL line on a converted word
  p_idsel_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && act_code == ACT_CONVERT) |-> $onehot0(act_ad[AW-1:SEL_LSB]));
  // R7: special cycle keeps Type 1 all-ones device/function encoding
  p_special_enc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && act_code == ACT_SPECIAL) |-> (act_ad[1:0] == 2'b01 && act_ad[15:8] == 8'hFF));
  // R10: single-phase flag tracks convert
  p_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> (act_single == (act_code == ACT_CONVERT)));
endmodule

// File: tb/cfgconv_top_bench.sv
`timescale 1ns/1ps
module cfgconv_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [3:0]  req_cmd;
  logic [31:0] req_ad;
  logic        own_idsel;
  logic [7:0]  sec_bus, sub_bus;
  logic        act_valid;
  logic [2:0]  act_code;
  logic [31:0] act_ad;
  logic        act_single;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  cfgconv_top u_cfgconv_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_ad(req_ad), .own_idsel(own_idsel), .sec_bus(sec_bus), .sub_bus(sub_bus),
    .act_valid(act_valid), .act_code(act_code), .act_ad(act_ad), .act_single(act_single)
  );

  // expected action from the requirements
  function automatic logic [2:0] exp_code(logic [3:0] c, logic [31:0] a, logic own,
                                          logic [7:0] s, logic [7:0] u);
    logic [7:0] b;
    b = a[23:16];
    if (c != 4'hA && c != 4'hB) return 3'd0;          // R9
    if (a[1:0] == 2'b00) return own ? 3'd1 : 3'd0;     // R3
    if (a[1:0] != 2'b01) return 3'd0;                  // R9
    if (b == s) begin
      if (c == 4'hB && a[15:11] == 5'd31 && a[10:8] == 3'd7) return 3'd4; // R7
      return 3'd2;                                     // R4
    end
    if (b > s && b <= u) return 3'd3;                  // R8
    return 3'd0;                                       // R9
  endfunction

  function automatic logic [31:0] exp_word(logic [2:0] code, logic [31:0] a);
    logic [31:0] w;
    case (code)
      3'd1, 3'd3, 3'd4: w = a;
      3'd2: begin
        w = {16'h0, 5'h0, a[10:2], 2'b00};
        if (a[15:11] <= 5'd8) w[16 + a[15:11]] = 1'b1; // R5, R6
      end
      default: w = 32'h0;
    endcase
    return w;
  endfunction

  function automatic string tag_of(logic [2:0] code, logic [31:0] a);
    case (code)
      3'd1: return "R3";
      3'd2: return (a[15:11] <= 5'd8) ? "R5" : "R6";
      3'd3: return "R8";
      3'd4: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [2:0] gc, logic [31:0] ga, logic gs, logic gv,
                       logic [2:0] ec, logic [31:0] ea, logic es, logic ev);
    n_chk++;
    if (gc !== ec || ga !== ea || gs !== es || gv !== ev) begin
      n_bad++;
      $display("FAIL %s: got code=%0d ad=%08h single=%0b valid=%0b, exp code=%0d ad=%08h single=%0b valid=%0b",
               tag, gc, ga, gs, gv, ec, ea, es, ev);
    end
  endtask

  // drive on a falling edge, result one rising edge later
  task automatic apply(logic [3:0] c, logic [31:0] a, logic own,
                       logic [7:0] s, logic [7:0] u, string tag_override);
    logic [2:0]  ec;
    logic [31:0] ea;
    string tag;
    req_cmd = c; req_ad = a; own_idsel = own; sec_bus = s; sub_bus = u;
    req_valid = 1'b1;
    ec = exp_code(c, a, own, s, u);
    ea = exp_word(ec, a);
    tag = (tag_override != "") ? tag_override : tag_of(ec, a);
    @(posedge clk); @(negedge clk);
    check(tag, act_code, act_ad, act_single, act_valid, ec, ea, (ec == 3'd2), 1'b1);
    if (ec == 3'd2) check("R4", act_code, act_ad & 32'h0000_FFFF, act_single, act_valid,
                          ec, {16'h0, 5'h0, a[10:2], 2'b00}, 1'b1, 1'b1);
    if (ec == 3'd2) check("R10", act_code, act_ad, act_single, act_valid, ec, ea, 1'b1, 1'b1);
    req_valid = 1'b0;
  endtask

  initial begin
    logic [2:0]  hc;
    logic [31:0] ha;
    logic        hs;
    int unsigned seed_tap;
    seed_tap = $urandom(32'd5150);
    rst_n = 1'b0; req_valid = 1'b0; req_cmd = 4'h0; req_ad = 32'h0;
    own_idsel = 1'b0; sec_bus = 8'd0; sub_bus = 8'd0;
    repeat (3) @(negedge clk);
    check("R1", act_code, act_ad, act_single, act_valid, 3'd0, 32'h0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", act_code, act_ad, act_single, act_valid, 3'd0, 32'h0, 1'b0, 1'b0);

    // directed corners
    apply(4'hA, 32'h0000_0104, 1'b1, 8'd5, 8'd9, "R3");
    apply(4'hA, 32'h0000_0104, 1'b0, 8'd5, 8'd9, "R3");
    for (int d = 0; d < 32; d++)
      apply(4'hA, {8'h0, 8'd5, 5'(d), 3'd2, 6'h15, 2'b01}, 1'b0, 8'd5, 8'd9, "");
    apply(4'hB, {8'h0, 8'd5, 5'd31, 3'd7, 6'h00, 2'b01}, 1'b0, 8'd5, 8'd9, "R7");
    apply(4'hA, {8'h0, 8'd5, 5'd31, 3'd7, 6'h00, 2'b01}, 1'b0, 8'd5, 8'd9, "R7");
    apply(4'hB, {8'h0, 8'd6, 5'd2, 3'd1, 6'h04, 2'b01}, 1'b0, 8'd5, 8'd9, "R8");
    apply(4'hB, {8'h0, 8'd9, 5'd2, 3'd1, 6'h04, 2'b01}, 1'b0, 8'd5, 8'd9, "R8");
    apply(4'hB, {8'h0, 8'd10, 5'd2, 3'd1, 6'h04, 2'b01}, 1'b0, 8'd5, 8'd9, "R9");
    apply(4'hB, {8'h0, 8'd4, 5'd2, 3'd1, 6'h04, 2'b01}, 1'b0, 8'd5, 8'd9, "R9");
    apply(4'h6, {8'h0, 8'd5, 5'd2, 3'd1, 6'h04, 2'b01}, 1'b1, 8'd5, 8'd9, "R9");
    apply(4'hA, {8'h0, 8'd5, 5'd2, 3'd1, 6'h04, 2'b11}, 1'b1, 8'd5, 8'd9, "R9");

    // R2: strobe drops after one cycle, outputs hold with a new word present
    apply(4'hA, {8'h0, 8'd5, 5'd3, 3'd0, 6'h01, 2'b01}, 1'b0, 8'd5, 8'd9, "R2");
    hc = act_code; ha = act_ad; hs = act_single;
    req_ad = {8'h0, 8'd7, 5'd1, 3'd0, 6'h00, 2'b01}; req_cmd = 4'hB;
    @(posedge clk); @(negedge clk);
    check("R2", act_code, act_ad, act_single, act_valid, hc, ha, hs, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R2", act_code, act_ad, act_single, act_valid, hc, ha, hs, 1'b0);

    // constrained random
    for (int n = 0; n < 600; n++) begin
      logic [7:0]  s, u, b;
      logic [3:0]  c;
      logic [1:0]  ty;
      logic [4:0]  d;
      logic [2:0]  f;
      int r;
      s = 8'($urandom_range(0, 200));
      u = s + 8'($urandom_range(0, 40));
      r = $urandom_range(0, 3);
      case (r)
        0: b = s;
        1: b = (u > s) ? 8'($urandom_range(int'(s) + 1, int'(u))) : s;
        2: b = 8'($urandom);
        default: b = u + 8'd1;
      endcase
      c  = ($urandom_range(0, 9) == 0) ? 4'($urandom) : ($urandom_range(0, 1) ? 4'hB : 4'hA);
      ty = ($urandom_range(0, 5) == 0) ? 2'($urandom) : 2'b01;
      d  = ($urandom_range(0, 7) == 0) ? 5'd31 : 5'($urandom_range(0, 12));
      f  = ($urandom_range(0, 3) == 0) ? 3'd7 : 3'($urandom);
      apply(c, {8'($urandom), b, d, f, 6'($urandom), ty}, 1'($urandom), s, u, "");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got no completion, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule